// File: doc/BRIEF.md
# Four-Stage Pipelined Floating-Point Adder

This block adds or subtracts two normalized floating-point operands in four register-separated segments. The first segment compares the exponents. The second aligns the smaller operand's mantissa to the larger exponent. The third adds or subtracts the two magnitudes. The fourth renormalizes the result. A new operand pair may enter on every clock, and a valid bit travels with the data, so a stream of operations completes at one result per cycle after a fixed fill delay.

Each operand has three parts: a sign bit, a signed two's-complement exponent, and an unsigned fractional magnitude. The magnitude is read as 0.m, with its most significant bit set when the operand is normalized. An all-zero magnitude encodes zero.

The block has no rounding modes, no special values and no exception flags. Guard bits below the mantissa carry alignment precision through the add, and the guard bits are truncated at the output. Keeping the exponent inside its range is the caller's job.

Top module: `fpadd_pipe4`

## Requirements
- R1: Each operand has three fields: sign (1 = negative), a signed EXP_W-bit two's-complement exponent, and an MAN_W-bit magnitude worth 0.m. Its value is (-1)^sign × 0.m × 2^exp. A nonzero magnitude has its bit MAN_W-1 set, and a magnitude of 0 means zero whatever the exponent.
- R2: With sub_i = 0 the result is A + B. With sub_i = 1 the sign of B is inverted before the operation, so the result is A − B.
- R3: An operation presented with valid_i high at a clock edge produces valid_o high exactly four edges later. valid_o is low in every cycle that has no such operation. Back-to-back operations are accepted every cycle.
- R4: The operand with the larger magnitude is the big operand; when the exponents differ this is the one with the larger exponent. The other magnitude is extended with GRD_W zero guard bits and shifted right by the exponent difference, and bits shifted out are dropped. A difference of at least MAN_W+GRD_W aligns it to zero.
- R5: When the aligned sum carries past the fraction point, the result magnitude is shifted right by one and the exponent is incremented by one.
- R6: When an effective subtraction leaves leading zeros, the magnitude is shifted left until its top bit is 1, and the exponent is decreased by the shift count.
- R7: A zero result is output with magnitude 0, exponent 0 and sign 0.
- R8: The result sign is the sign of the larger-magnitude operand, with B's sign taken after the sub_i inversion.
- R9: The output magnitude is the top MAN_W bits of the normalized extended value. The GRD_W guard bits are truncated.
- R10: While rst_ni is low, valid_o, res_sign_o, res_exp_o and res_man_o are all 0.
- R11: A valid nonzero result is normalized: bit MAN_W-1 of res_man_o is 1, and res_exp_o is no more than the larger input exponent plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair present this cycle |
| sub_i | input | 1 | 1 = subtract B from A, 0 = add |
| a_sign_i | input | 1 | Sign of A |
| a_exp_i | input | EXP_W | Exponent of A, two's complement |
| a_man_i | input | MAN_W | Fractional magnitude of A |
| b_sign_i | input | 1 | Sign of B |
| b_exp_i | input | EXP_W | Exponent of B, two's complement |
| b_man_i | input | MAN_W | Fractional magnitude of B |
| valid_o | output | 1 | Result present this cycle |
| res_sign_o | output | 1 | Sign of result |
| res_exp_o | output | EXP_W | Exponent of result, two's complement |
| res_man_o | output | MAN_W | Fractional magnitude of result |

## Verification
The assertions check the following on every cycle:
- the four-edge relation between valid_i and valid_o;
- that a nonzero valid result has its top magnitude bit set;
- that a zero result carries exponent 0 and a positive sign;
- that the result exponent never exceeds the larger input exponent by more than one.

Only the bench's scenarios can show the numeric content of each result. This covers the choice of the big operand, the guard-bit truncation during alignment, the carry and leading-zero renormalization amounts, the sign taken from the larger magnitude, and the clamp to zero for large exponent gaps. The bench checks these against its own model, over directed corner cases and a random stream that mixes back-to-back issue with gaps.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic {
    EFF_ADD = 1'b0,
    EFF_SUB = 1'b1
  } eff_op_e;
endpackage

// File: rtl/fpadd_s1_cmp.sv
module fpadd_s1_cmp #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16,
  parameter int GRD_W = 2,
  localparam int XW   = MAN_W + GRD_W,
  localparam int SHW  = $clog2(XW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sub_i,
  input  logic             a_sign_i,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic [MAN_W-1:0] a_man_i,
  input  logic             b_sign_i,
  input  logic [EXP_W-1:0] b_exp_i,
  input  logic [MAN_W-1:0] b_man_i,
  output logic             valid_o,
  output logic             big_sign_o,
  output logic [EXP_W-1:0] big_exp_o,
  output logic [MAN_W-1:0] big_man_o,
  output logic             sml_sign_o,
  output logic [MAN_W-1:0] sml_man_o,
  output logic [SHW-1:0]   shamt_o
);
  logic signed [EXP_W:0] ae_x, be_x, diff;
  logic                  a_big, b_sign_eff;
  logic [SHW-1:0]        shamt_d;
  int                    diff_i;

  assign ae_x       = {a_exp_i[EXP_W-1], a_exp_i};
  assign be_x       = {b_exp_i[EXP_W-1], b_exp_i};
  assign b_sign_eff = b_sign_i ^ sub_i;

  // zero magnitude always loses; equal exponents decided by magnitude
  always_comb begin
    a_big = (a_man_i != '0) &&
            ((b_man_i == '0) ||
             ($signed(a_exp_i) > $signed(b_exp_i)) ||
             ((a_exp_i == b_exp_i) && (a_man_i >= b_man_i)));
    diff   = a_big ? (ae_x - be_x) : (be_x - ae_x);
    diff_i = int'(diff);
    if (diff_i < 0 || diff_i >= XW) shamt_d = SHW'(XW);
    else                            shamt_d = SHW'(diff_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      big_sign_o <= 1'b0;
      big_exp_o  <= '0;
      big_man_o  <= '0;
      sml_sign_o <= 1'b0;
      sml_man_o  <= '0;
      shamt_o    <= '0;
    end else begin
      valid_o    <= valid_i;
      big_sign_o <= a_big ? a_sign_i : b_sign_eff;
      big_exp_o  <= a_big ? a_exp_i  : b_exp_i;
      big_man_o  <= a_big ? a_man_i  : b_man_i;
      sml_sign_o <= a_big ? b_sign_eff : a_sign_i;
      sml_man_o  <= a_big ? b_man_i  : a_man_i;
      shamt_o    <= shamt_d;
    end
  end
endmodule

// File: rtl/fpadd_s2_align.sv
module fpadd_s2_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16,
  parameter int GRD_W = 2,
  localparam int XW   = MAN_W + GRD_W,
  localparam int SHW  = $clog2(XW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             big_sign_i,
  input  logic [EXP_W-1:0] big_exp_i,
  input  logic [MAN_W-1:0] big_man_i,
  input  logic             sml_sign_i,
  input  logic [MAN_W-1:0] sml_man_i,
  input  logic [SHW-1:0]   shamt_i,
  output logic             valid_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output eff_op_e          op_o,
  output logic [XW-1:0]    big_x_o,
  output logic [XW-1:0]    sml_x_o
);
  logic [XW-1:0] big_ext, sml_ext, sml_al;

  assign big_ext = XW'(big_man_i) << GRD_W;
  assign sml_ext = XW'(sml_man_i) << GRD_W;

  always_comb begin
    if (shamt_i >= SHW'(XW)) sml_al = '0;
    else                     sml_al = sml_ext >> shamt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      exp_o   <= '0;
      op_o    <= EFF_ADD;
      big_x_o <= '0;
      sml_x_o <= '0;
    end else begin
      valid_o <= valid_i;
      sign_o  <= big_sign_i;
      exp_o   <= big_exp_i;
      op_o    <= (big_sign_i != sml_sign_i) ? EFF_SUB : EFF_ADD;
      big_x_o <= big_ext;
      sml_x_o <= sml_al;
    end
  end
endmodule

// File: rtl/fpadd_s3_addsub.sv
module fpadd_s3_addsub
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16,
  parameter int GRD_W = 2,
  localparam int XW   = MAN_W + GRD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  eff_op_e          op_i,
  input  logic [XW-1:0]    big_x_i,
  input  logic [XW-1:0]    sml_x_i,
  output logic             valid_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [XW:0]      sum_o
);
  logic [XW:0] sum_d;

  // big magnitude >= aligned small, so the difference never goes negative
  always_comb begin
    if (op_i == EFF_SUB) sum_d = {1'b0, big_x_i} - {1'b0, sml_x_i};
    else                 sum_d = {1'b0, big_x_i} + {1'b0, sml_x_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      exp_o   <= '0;
      sum_o   <= '0;
    end else begin
      valid_o <= valid_i;
      sign_o  <= sign_i;
      exp_o   <= exp_i;
      sum_o   <= sum_d;
    end
  end
endmodule

// File: rtl/fpadd_s4_norm.sv
module fpadd_s4_norm #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16,
  parameter int GRD_W = 2,
  localparam int XW   = MAN_W + GRD_W,
  localparam int LZW  = $clog2(XW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [XW:0]      sum_i,
  output logic             valid_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W-1:0] man_o
);
  logic [LZW-1:0]   lz;
  logic             found;
  logic [XW-1:0]    nx;
  logic [EXP_W-1:0] ne;
  logic             ns;

  always_comb begin
    lz    = LZW'(XW);
    found = 1'b0;
    for (int i = XW - 1; i >= 0; i--) begin
      if (!found && sum_i[i]) begin
        lz    = LZW'(XW - 1 - i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    ns = sign_i;
    if (sum_i[XW]) begin
      nx = sum_i[XW:1];
      ne = exp_i + 1'b1;
    end else if (sum_i == '0) begin
      nx = '0;
      ne = '0;
      ns = 1'b0;
    end else begin
      nx = sum_i[XW-1:0] << lz;
      ne = exp_i - EXP_W'(lz);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      exp_o   <= '0;
      man_o   <= '0;
    end else begin
      valid_o <= valid_i;
      sign_o  <= ns;
      exp_o   <= ne;
      man_o   <= nx[XW-1:GRD_W];
    end
  end
endmodule

// File: rtl/fpadd_pipe4.sv
module fpadd_pipe4
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16,
  parameter int GRD_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sub_i,
  input  logic             a_sign_i,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic [MAN_W-1:0] a_man_i,
  input  logic             b_sign_i,
  input  logic [EXP_W-1:0] b_exp_i,
  input  logic [MAN_W-1:0] b_man_i,
  output logic             valid_o,
  output logic             res_sign_o,
  output logic [EXP_W-1:0] res_exp_o,
  output logic [MAN_W-1:0] res_man_o
);
  localparam int XW  = MAN_W + GRD_W;
  localparam int SHW = $clog2(XW + 1);

  logic             s1_valid, s1_big_sign, s1_sml_sign;
  logic [EXP_W-1:0] s1_big_exp;
  logic [MAN_W-1:0] s1_big_man, s1_sml_man;
  logic [SHW-1:0]   s1_shamt;

  logic             s2_valid, s2_sign;
  logic [EXP_W-1:0] s2_exp;
  eff_op_e          s2_op;
  logic [XW-1:0]    s2_big_x, s2_sml_x;

  logic             s3_valid, s3_sign;
  logic [EXP_W-1:0] s3_exp;
  logic [XW:0]      s3_sum;

  fpadd_s1_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_s1 (
    .clk_i, .rst_ni, .valid_i, .sub_i,
    .a_sign_i, .a_exp_i, .a_man_i, .b_sign_i, .b_exp_i, .b_man_i,
    .valid_o    (s1_valid),
    .big_sign_o (s1_big_sign),
    .big_exp_o  (s1_big_exp),
    .big_man_o  (s1_big_man),
    .sml_sign_o (s1_sml_sign),
    .sml_man_o  (s1_sml_man),
    .shamt_o    (s1_shamt)
  );

  fpadd_s2_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_s2 (
    .clk_i, .rst_ni,
    .valid_i    (s1_valid),
    .big_sign_i (s1_big_sign),
    .big_exp_i  (s1_big_exp),
    .big_man_i  (s1_big_man),
    .sml_sign_i (s1_sml_sign),
    .sml_man_i  (s1_sml_man),
    .shamt_i    (s1_shamt),
    .valid_o    (s2_valid),
    .sign_o     (s2_sign),
    .exp_o      (s2_exp),
    .op_o       (s2_op),
    .big_x_o    (s2_big_x),
    .sml_x_o    (s2_sml_x)
  );

  fpadd_s3_addsub #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_s3 (
    .clk_i, .rst_ni,
    .valid_i (s2_valid),
    .sign_i  (s2_sign),
    .exp_i   (s2_exp),
    .op_i    (s2_op),
    .big_x_i (s2_big_x),
    .sml_x_i (s2_sml_x),
    .valid_o (s3_valid),
    .sign_o  (s3_sign),
    .exp_o   (s3_exp),
    .sum_o   (s3_sum)
  );

  fpadd_s4_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_s4 (
    .clk_i, .rst_ni,
    .valid_i (s3_valid),
    .sign_i  (s3_sign),
    .exp_i   (s3_exp),
    .sum_i   (s3_sum),
    .valid_o (valid_o),
    .sign_o  (res_sign_o),
    .exp_o   (res_exp_o),
    .man_o   (res_man_o)
  );
endmodule

// File: rtl/fpadd_pipe4_chk.sv
module fpadd_pipe4_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16,
  parameter int GRD_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             sub_i,
  input logic             a_sign_i,
  input logic [EXP_W-1:0] a_exp_i,
  input logic [MAN_W-1:0] a_man_i,
  input logic             b_sign_i,
  input logic [EXP_W-1:0] b_exp_i,
  input logic [MAN_W-1:0] b_man_i,
  input logic             valid_o,
  input logic             res_sign_o,
  input logic [EXP_W-1:0] res_exp_o,
  input logic [MAN_W-1:0] res_man_o
);
  logic [2:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4) |-> (valid_o == $past(valid_i, 4)));

  assert_normalized_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && res_man_o != '0) |-> res_man_o[MAN_W-1]);

  assert_zero_form_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && res_man_o == '0) |-> (res_exp_o == '0 && !res_sign_o));

  assert_exp_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4 && valid_o && res_man_o != '0) |->
      (($signed(res_exp_o) <= $signed($past(a_exp_i, 4)) + 1) ||
       ($signed(res_exp_o) <= $signed($past(b_exp_i, 4)) + 1)));
endmodule

bind fpadd_pipe4 fpadd_pipe4_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) u_chk (.*);

// File: tb/sim_fpadd_pipe4.sv
module sim_fpadd_pipe4;
  localparam int EW = 8;
  localparam int MW = 16;
  localparam int GW = 2;
  localparam int XW = MW + GW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0, sub_i = 1'b0;
  logic          a_sign_i = 1'b0, b_sign_i = 1'b0;
  logic [EW-1:0] a_exp_i = '0, b_exp_i = '0;
  logic [MW-1:0] a_man_i = '0, b_man_i = '0;
  logic          valid_o, res_sign_o;
  logic [EW-1:0] res_exp_o;
  logic [MW-1:0] res_man_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  fpadd_pipe4 #(.EXP_W(EW), .MAN_W(MW), .GRD_W(GW)) u0 (.*);

  typedef struct {
    logic          s;
    logic [EW-1:0] e;
    logic [MW-1:0] m;
    int            due;
    string         tag;
  } item_t;

  item_t q[$];
  int    errors = 0, checks = 0, cyc = 0;
  bit    done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic item_t model(logic as, int ae, int am, logic bs, int be,
                                  int bm, logic sub);
    item_t  r;
    logic   bse, bgs;
    int     bge, sme, d, e;
    longint bgm, smm, bx, sx, v;
    bse = bs ^ sub;  // R2
    r.s = 1'b0; r.e = '0; r.m = '0;
    if (am == 0 && bm == 0) return r;
    if (bm == 0 || (am != 0 && (ae > be || (ae == be && am >= bm)))) begin
      bgs = as; bge = ae; bgm = am; sme = be; smm = bm;
    end else begin
      bgs = bse; bge = be; bgm = bm; sme = ae; smm = am;
    end
    d  = bge - sme;
    bx = bgm * (64'sd1 << GW);
    if (smm == 0 || d >= XW) sx = 0;
    else sx = (smm * (64'sd1 << GW)) / (64'sd1 << d);
    v = (as == bse) ? bx + sx : bx - sx;
    e = bge;
    if (v == 0) return r;
    while (v >= (64'sd1 << XW)) begin v = v / 2; e++; end
    while (v < (64'sd1 << (XW - 1))) begin v = v * 2; e--; end
    r.s = bgs;
    r.e = EW'(e);
    r.m = MW'(v / (64'sd1 << GW));
    return r;
  endfunction

  task automatic send(string tag, logic as, int ae, int am, logic bs, int be,
                      int bm, logic sub);
    item_t it;
    @(negedge clk_i);
    valid_i = 1'b1; sub_i = sub;
    a_sign_i = as; a_exp_i = EW'(ae); a_man_i = MW'(am);
    b_sign_i = bs; b_exp_i = EW'(be); b_man_i = MW'(bm);
    it = model(as, ae, am, bs, be, bm, sub);
    it.due = cyc + 4;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      a_man_i = MW'($urandom);
      b_man_i = MW'($urandom);
    end
  endtask

  task automatic chk(string req, logic ok, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic int rnd_man();
    return int'({1'b1, MW'($urandom)} >> 1) | (1 << (MW - 1));
  endfunction

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (q.size() == 0) begin
          chk("R3", 1'b0, "valid_o=1", "no result pending");
        end else begin
          item_t h;
          h = q.pop_front();
          chk("R3", h.due == cyc, $sformatf("cycle %0d", cyc),
              $sformatf("cycle %0d", h.due));
          chk(h.tag, {res_sign_o, res_exp_o, res_man_o} == {h.s, h.e, h.m},
              $sformatf("s=%0b e=%0d m=%h", res_sign_o, $signed(res_exp_o), res_man_o),
              $sformatf("s=%0b e=%0d m=%h", h.s, $signed(h.e), h.m));
        end
      end else if (q.size() != 0 && q[0].due <= cyc) begin
        chk("R3", 1'b0, "valid_o=0", $sformatf("result due at cycle %0d", q[0].due));
        void'(q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: outputs zero in reset even with inputs active
    valid_i = 1'b1; a_man_i = 16'hC000; b_man_i = 16'h8000;
    repeat (3) @(negedge clk_i);
    chk("R10", valid_o == 1'b0, $sformatf("%0b", valid_o), "0");
    chk("R10", {res_sign_o, res_exp_o, res_man_o} == '0,
        $sformatf("%h", {res_sign_o, res_exp_o, res_man_o}), "0");
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);

    send("R5",  0, 3, 16'hC000, 0, 3, 16'hC000, 0);   // carry
    send("R4",  0, 5, 16'h8000, 0, 2, 16'hF000, 0);   // align by 3
    send("R4",  0, 10, 16'h9000, 0, -15, 16'hFFFF, 0); // gap 25 -> zero
    send("R4",  0, 4, 16'h8000, 0, -13, 16'hFFFF, 0); // gap 17, guard only
    send("R6",  0, 0, 16'h8001, 0, 0, 16'h8000, 1);   // 15 leading zeros
    send("R6",  0, 1, 16'h8000, 0, 0, 16'hFFFF, 1);   // near cancel
    send("R8",  0, 1, 16'h8000, 0, 1, 16'hC000, 1);   // B bigger, negative
    send("R8",  1, 2, 16'hA000, 0, 6, 16'h8000, 0);   // B bigger, positive
    send("R7",  0, 7, 16'hB123, 0, 7, 16'hB123, 1);   // exact cancel
    send("R7",  1, -4, 16'h0, 0, 9, 16'h0, 0);        // both zero
    send("R1",  0, -9, 16'h0, 1, 3, 16'hD00D, 0);     // A zero
    send("R2",  0, 2, 16'h8000, 1, 2, 16'h8000, 1);   // sub of negative
    send("R9",  0, 0, 16'h8000, 0, -3, 16'hFFFF, 0);  // truncation
    send("R9",  0, 0, 16'hFFFF, 0, 0, 16'hFFFF, 0);   // carry drops lsb
    idle(6);

    // back-to-back random stream
    for (int i = 0; i < 300; i++) begin
      send("R3", 1'($urandom), $signed(6'($urandom)) >>> 1, rnd_man(),
           1'($urandom), $signed(6'($urandom)) >>> 1, rnd_man(), 1'($urandom));
    end
    // random with gaps and near-equal exponents
    for (int i = 0; i < 200; i++) begin
      int e = $signed(4'($urandom));
      send("R6", 1'($urandom), e, rnd_man(), 1'($urandom), e + int'($urandom_range(0, 2)),
           rnd_man(), 1'($urandom));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 5)));
    end
    idle(10);
    chk("R3", q.size() == 0, $sformatf("%0d pending", q.size()), "0 pending");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule